// File: doc/BRIEF.md
# Programmable Flash Timing Tick Divider

This block turns the bus clock into a slow, evenly spaced timing tick for a nonvolatile memory controller. Software writes one 8-bit control register. That register selects an optional fixed divide-by-8 prescaler and a 6-bit divisor. The block then emits a single-bus-cycle enable pulse at the bus rate divided by (divisor + 1), or by 8 × (divisor + 1) when the prescaler is selected. A downstream program/erase sequencer counts these pulses. The tick is a clock enable, not a new clock. Divisor values are normally chosen so that the tick rate lands between 150 kHz and 200 kHz.

The register also carries a read-only "configured" flag. Reset clears the flag. The first register write sets it, whatever data that write carries. The flag drives a program/erase permission output, so the nonvolatile memory cannot be erased or programmed until software has set up the divider at least once. Every register write also restarts the prescaler and the divide counter, so a new setting takes effect from a clean phase.

Top module: `nvm_clk_divider`

## Requirements
- R1: After reset, the read port returns 0x00 and `progEnable` is low.
- R2: The first register write sets the configured flag (read bit 7), whatever the data. Later writes never clear it. Only reset clears it.
- R3: `progEnable` is low while the configured flag is 0 and high while it is 1.
- R4: Write data bit 7 is ignored. Writing 0x00 or 0x80 gives the same readback.
- R5: A write stores data bit 6 as the prescale select and bits 5:0 as the divisor. Both read back in the same positions.
- R6: With prescale select 0 and divisor N, `tick` pulses every N+1 bus cycles. The first pulse comes N cycles after the write cycle (cycle 0 is the first cycle after the write edge). N = 0 gives a pulse on every cycle.
- R7: With prescale select 1 and divisor N, `tick` pulses every 8·(N+1) bus cycles. The first pulse comes in cycle 8·N+7 after the write.
- R8: Each `tick` pulse lasts exactly one bus cycle whenever the divisor is nonzero or prescaling is selected.
- R9: A register write restarts both counters. A rewrite in mid-period yields the first pulse at the R6/R7 offset counted from the rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data: bit 6 prescale select, bits 5:0 divisor, bit 7 ignored |
| rdData | output | 8 | Readback: bit 7 configured flag, bit 6 prescale select, bits 5:0 divisor |
| tick | output | 1 | One-cycle timing enable at the divided rate |
| progEnable | output | 1 | Program/erase permission, equal to the configured flag |

## Verification
The bench sweeps divisors 0, 4, 9, 19, 39 and 49 with the prescaler off and on. For each setting it measures the offset of the first tick and the spacing of the next two. An off-by-one in the reload compare shows up as a spacing of N or N+2. A prescaler that fires on its first count instead of its eighth shifts the first tick. For the flag, the bench writes all-zero data first and then 0x80 against 0x00. This exposes a flag that depends on the data value, and a bit 7 that leaks into storage or can clear the flag. A mid-period rewrite exposes counters that a write fails to restart: such a design would place the next tick at the old phase instead of N cycles later.

// File: rtl/nvm_clk_pkg.sv
package nvm_clk_pkg;
  // Strobes passed from the register control to the counting datapath
  typedef struct packed {
    logic restart;      // clear both counters this cycle
    logic usePrescale;  // advance main counter only on prescaler wrap
  } divStrobe_t;
endpackage

// File: rtl/nvm_clk_ctrl.sv
module nvm_clk_ctrl
  import nvm_clk_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [DIV_W+1:0]     wrData,
  output divStrobe_t           strobe,
  output logic [DIV_W-1:0]     divisor,
  output logic [DIV_W+1:0]     rdData,
  output logic                 progEnable
);
  localparam int PRE_BIT = DIV_W;

  logic             loadedQ;
  logic             preSelQ;
  logic [DIV_W-1:0] divQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadedQ <= 1'b0;
      preSelQ <= 1'b0;
      divQ    <= '0;
    end else if (wrEn) begin
      loadedQ <= 1'b1;  // any write marks the divider configured
      preSelQ <= wrData[PRE_BIT];
      divQ    <= wrData[DIV_W-1:0];
    end
  end

  always_comb begin
    strobe.restart     = wrEn;
    strobe.usePrescale = preSelQ;
  end

  assign divisor    = divQ;
  assign rdData     = {loadedQ, preSelQ, divQ};
  assign progEnable = loadedQ;
endmodule

// File: rtl/nvm_clk_datapath.sv
module nvm_clk_datapath
  import nvm_clk_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] mainCnt;
  logic             preFire;
  logic             advance;
  logic             hit;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) preCnt <= '0;
    else                         preCnt <= preCnt + 1'b1;
  end

  assign preFire = (preCnt == PRE_LAST);
  assign advance = strobe.usePrescale ? preFire : 1'b1;
  assign hit     = advance && (mainCnt == divisor);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) mainCnt <= '0;
    else if (advance)            mainCnt <= hit ? '0 : mainCnt + 1'b1;
  end

  assign tick = hit;
endmodule

// File: rtl/nvm_clk_divider.sv
module nvm_clk_divider
  import nvm_clk_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [DIV_W+1:0] wrData,
  output logic [DIV_W+1:0] rdData,
  output logic             tick,
  output logic             progEnable
);
  divStrobe_t       strobe;
  logic [DIV_W-1:0] divisor;

  nvm_clk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .divisor(divisor), .rdData(rdData),
    .progEnable(progEnable)
  );

  nvm_clk_datapath #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divisor(divisor),
    .tick(tick)
  );
endmodule

// File: rtl/nvm_clk_divider_chk.sv
module nvm_clk_divider_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [DIV_W+1:0] wrData,
  input logic [DIV_W+1:0] rdData,
  input logic             tick,
  input logic             progEnable
);
  AST_WRITE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[DIV_W+1]); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DIV_W+1] |=> rdData[DIV_W+1]); // R2

  AST_PROG_GATED: assert property (@(posedge clk) disable iff (!rstN)
    progEnable == rdData[DIV_W+1]); // R3

  AST_FIELD_STORE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[DIV_W:0] == $past(wrData[DIV_W:0])); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && rdData[DIV_W-1:0] != '0) |=> !tick); // R8

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[DIV_W-1:0] != '0) |=> !tick); // R9
endmodule

bind nvm_clk_divider nvm_clk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .tick(tick), .progEnable(progEnable)
);

// File: tb/nvm_clk_divider_bench.sv
module nvm_clk_divider_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tick;
  logic       progEnable;

  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nvm_clk_divider u_nvm_clk_divider (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .tick(tick), .progEnable(progEnable)
  );

  task automatic check(input string req, input int act, input int exp);
    runCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write on one cycle; returns at the negedge of cycle 0 after the write edge
  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Measure first tick offset and two spacings; caller is at cycle 0
  task automatic measure(input bit pre, input int n, input string req);
    int firstExp = pre ? 8 * n + 7 : n;
    int perExp   = pre ? 8 * (n + 1) : n + 1;
    int found[3];
    int k = 0;
    for (int cyc = 0; cyc < 2000 && k < 3; cyc++) begin
      if (tick) begin
        found[k] = cyc;
        k++;
      end
      if (k < 3) @(negedge clk);
    end
    check(req, k, 3);
    if (k == 3) begin
      check(req, found[0], firstExp);
      check(req, found[1] - found[0], perExp);
      check(req, found[2] - found[1], perExp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      runCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int divList[6] = '{0, 4, 9, 19, 39, 49};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 0);
    check("R1 progEnable", progEnable, 0);
    // R3 permission off before any write
    repeat (5) @(negedge clk);
    check("R3 progEnable before write", progEnable, 0);

    // R2 first write with all-zero data still sets flag
    regWrite(8'h00);
    check("R2 flag after zero write", rdData, 8'h80);
    check("R3 progEnable after write", progEnable, 1);

    // R4 bit 7 of write data ignored
    regWrite(8'h80 | 8'h15);
    check("R4 readback with bit7 set", rdData, 8'h95);
    regWrite(8'h15);
    check("R4 readback with bit7 clear", rdData, 8'h95);

    // R5 field positions
    regWrite(8'h6A);
    check("R5 prescale bit6 and divisor", rdData, 8'hEA);
    check("R2 flag sticky", rdData[7], 1);

    // R6/R7/R8 sweep
    for (int p = 0; p < 2; p++) begin
      foreach (divList[i]) begin
        regWrite({1'b0, p[0], divList[i][5:0]});
        measure(p[0], divList[i], p[0] ? "R7 prescaled spacing (R8)" : "R6 direct spacing (R8)");
      end
    end

    // R9 mid-period rewrite restarts the phase
    regWrite(8'h09);
    repeat (5) @(negedge clk);
    regWrite(8'h09);
    measure(1'b0, 9, "R9 restart direct");
    regWrite(8'h42);
    repeat (13) @(negedge clk);
    regWrite(8'h42);
    measure(1'b1, 2, "R9 restart prescaled");

    // R2 reset clears flag again
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset clears flag", rdData, 0);
    check("R3 progEnable after reset", progEnable, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule